// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block sits between a byte-wide host bus and the priority core of an eight-line interrupt controller. The host sees two byte addresses. The sequencer sorts each write into a configuration step, a mask load, an end-of-interrupt command or a read-select change. It holds the configuration that the priority core consumes: vector base, trigger style, single or cascade operation, the downstream-controller map or own slave ID, and automatic end-of-interrupt.

Offset 0 carries three kinds of command, and bits 4 and 3 of the data tell them apart. What a write to offset 1 means depends on where the initialization sequence stands. That sequence has up to four steps. It skips the third step in single mode, and it skips the fourth step when the first step did not ask for it.

End-of-interrupt commands leave the block as a one-cycle pulse. The pulse carries a line number and a flag that says whether the line was named by the host. Reads are a combinational multiplex of the mask, pending and in-service registers. The pending and in-service values come from the priority core.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the sequence is idle, the mask is 0x00, auto-EOI is 0, no EOI pulse is driven, and a read of offset 0 returns `pend_i`.
- R2: A write to offset 0 with bit 4 set starts initialization. From the next cycle the mask is 0x00, `trig_edge_o` equals data bit 3 and `cascade_o` equals the inverse of data bit 1. The next write to offset 1 is taken as the vector-base step and does not load the mask.
- R3: A start-of-initialization write with data bit 0 clear forces `auto_eoi_o` to 0. With data bit 0 set, `auto_eoi_o` keeps its value.
- R4: The vector-base step stores the data with bits 2:0 forced to 0. In single mode it also clears the cascade map and returns to idle, even when a fourth step was requested.
- R5: In cascade mode the next offset-1 write is the cascade step. With `is_master_i`=1 it stores the whole byte in `casc_map_o`. With `is_master_i`=0 it stores only bits 2:0, and the upper bits are 0. The sequence then returns to idle unless a fourth step was requested.
- R6: The fourth step sets `auto_eoi_o` to data bit 1, leaves the mask untouched and returns to idle.
- R7: A write to offset 1 while idle loads the mask. Configuration outputs change only on writes.
- R8: A write to offset 0 with bits 4:3 = 00 and bits 7:5 = 001 gives a one-cycle pulse on `eoi_valid_o` in the cycle after the write, with `eoi_specific_o`=0 and `eoi_line_o`=0. Code 011 gives the same pulse with `eoi_specific_o`=1 and `eoi_line_o` = data bits 2:0.
- R9: The other values of bits 7:5 in such a write give no pulse and change no configuration.
- R10: A write to offset 0 with bits 4:3 = 01 and bit 1 set makes offset-0 reads return `pend_i` when data bit 0 is 1, or `insvc_i` when it is 0. With bit 1 clear the selection is unchanged.
- R11: `rdata_o` follows `addr_i` in the same cycle. Offset 1 returns the mask and offset 0 returns the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| is_master_i | input | 1 | Role tie-off: 1 means master, 0 means slave |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| addr_i | input | 1 | Register offset (0 or 1) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pend_i | input | 8 | Pending register from the priority core |
| insvc_i | input | 8 | In-service register from the priority core |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, bits 2:0 always 0 |
| trig_edge_o | output | 1 | 1 means edge-triggered, 0 means level-triggered |
| cascade_o | output | 1 | 1 means cascade mode, 0 means single mode |
| casc_map_o | output | 8 | Downstream map (master) or slave ID (slave) |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt enable |
| rd_pend_sel_o | output | 1 | 1 means offset-0 reads return pending, 0 means in-service |
| eoi_valid_o | output | 1 | One-cycle end-of-interrupt command |
| eoi_specific_o | output | 1 | The command names a line |
| eoi_line_o | output | 3 | Line for a specific command, 0 otherwise |

## Verification
A wrong sequence state shows up one write late. The next offset-1 byte lands in the wrong field, so either the mask changes when it should have held or a configuration field keeps its old value. The bench therefore follows every multi-step sequence with a mask write and reads the mask back. A decode fault among the command kinds shows up in the cycle after the write. It appears as a missing or extra EOI pulse, or as a read of offset 0 that returns the wrong source.

// File: rtl/pic_cmd_pkg.sv
`timescale 1ns/1ps
package pic_cmd_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_W2, SEQ_W3, SEQ_W4} seq_e;
  typedef enum logic [2:0] {CMD_NONE, CMD_INIT1, CMD_OP2, CMD_OP3, CMD_PORT1} cmd_e;
endpackage

// File: rtl/pic_cmd_decode.sv
`timescale 1ns/1ps
module pic_cmd_decode
  import pic_cmd_pkg::*;
(
  input  logic       wr_en_i,
  input  logic       addr_i,
  input  logic [1:0] sel_i,   // data bits 4:3
  output cmd_e       cmd_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (wr_en_i) begin
      if (addr_i)         cmd_o = CMD_PORT1;
      else if (sel_i[1])  cmd_o = CMD_INIT1;
      else if (sel_i[0])  cmd_o = CMD_OP3;
      else                cmd_o = CMD_OP2;
    end
  end
endmodule

// File: rtl/pic_init_fsm.sv
`timescale 1ns/1ps
module pic_init_fsm
  import pic_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LINE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              is_master_i,
  input  cmd_e              cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] vec_base_o,
  output logic              trig_edge_o,
  output logic              cascade_o,
  output logic [DATA_W-1:0] casc_map_o,
  output logic              auto_eoi_o,
  output logic              rd_pend_sel_o
);
  seq_e state_q;
  logic need_w4_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= SEQ_IDLE;
      need_w4_q     <= 1'b0;
      mask_o        <= '0;
      vec_base_o    <= '0;
      trig_edge_o   <= 1'b0;
      cascade_o     <= 1'b0;
      casc_map_o    <= '0;
      auto_eoi_o    <= 1'b0;
      rd_pend_sel_o <= 1'b1;
    end else begin
      unique case (cmd_i)
        CMD_INIT1: begin
          mask_o      <= '0;
          trig_edge_o <= wdata_i[3];
          cascade_o   <= ~wdata_i[1];
          need_w4_q   <= wdata_i[0];
          if (!wdata_i[0]) auto_eoi_o <= 1'b0;
          state_q     <= SEQ_W2;
        end
        CMD_OP3: if (wdata_i[1]) rd_pend_sel_o <= wdata_i[0];
        CMD_PORT1: begin
          unique case (state_q)
            SEQ_IDLE: mask_o <= wdata_i;
            SEQ_W2: begin
              vec_base_o <= {wdata_i[DATA_W-1:LINE_W], {LINE_W{1'b0}}};
              if (cascade_o) state_q <= SEQ_W3;
              else begin
                casc_map_o <= '0;
                state_q    <= SEQ_IDLE;
              end
            end
            SEQ_W3: begin
              casc_map_o <= is_master_i ? wdata_i
                          : {{(DATA_W-LINE_W){1'b0}}, wdata_i[LINE_W-1:0]};
              state_q    <= need_w4_q ? SEQ_W4 : SEQ_IDLE;
            end
            SEQ_W4: begin
              auto_eoi_o <= wdata_i[1];
              state_q    <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_eoi_gen.sv
`timescale 1ns/1ps
module pic_eoi_gen #(
  parameter int LINE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op2_i,
  input  logic [2:0]        code_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              eoi_valid_o,
  output logic              eoi_specific_o,
  output logic [LINE_W-1:0] eoi_line_o
);
  logic nonspec, spec;
  assign nonspec = op2_i && (code_i == 3'b001);
  assign spec    = op2_i && (code_i == 3'b011);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoi_valid_o    <= 1'b0;
      eoi_specific_o <= 1'b0;
      eoi_line_o     <= '0;
    end else begin
      eoi_valid_o    <= nonspec | spec;
      eoi_specific_o <= spec;
      eoi_line_o     <= spec ? line_i : '0;
    end
  end
endmodule

// File: rtl/pic_rd_mux.sv
`timescale 1ns/1ps
module pic_rd_mux #(
  parameter int DATA_W = 8
) (
  input  logic              addr_i,
  input  logic              rd_pend_sel_i,
  input  logic [DATA_W-1:0] pend_i,
  input  logic [DATA_W-1:0] insvc_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    if (addr_i)             rdata_o = mask_i;
    else if (rd_pend_sel_i) rdata_o = pend_i;
    else                    rdata_o = insvc_i;
  end
endmodule

// File: rtl/pic_cmd_seq.sv
`timescale 1ns/1ps
module pic_cmd_seq
  import pic_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int LINE_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              is_master_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] pend_i,
  input  logic [DATA_W-1:0] insvc_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] vec_base_o,
  output logic              trig_edge_o,
  output logic              cascade_o,
  output logic [DATA_W-1:0] casc_map_o,
  output logic              auto_eoi_o,
  output logic              rd_pend_sel_o,
  output logic              eoi_valid_o,
  output logic              eoi_specific_o,
  output logic [LINE_W-1:0] eoi_line_o
);
  cmd_e cmd;

  pic_cmd_decode u_decode (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .sel_i   (wdata_i[4:3]),
    .cmd_o   (cmd)
  );

  pic_init_fsm #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .is_master_i   (is_master_i),
    .cmd_i         (cmd),
    .wdata_i       (wdata_i),
    .mask_o        (mask_o),
    .vec_base_o    (vec_base_o),
    .trig_edge_o   (trig_edge_o),
    .cascade_o     (cascade_o),
    .casc_map_o    (casc_map_o),
    .auto_eoi_o    (auto_eoi_o),
    .rd_pend_sel_o (rd_pend_sel_o)
  );

  pic_eoi_gen #(.LINE_W(LINE_W)) u_eoi (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .op2_i          (cmd == CMD_OP2),
    .code_i         (wdata_i[7:5]),
    .line_i         (wdata_i[LINE_W-1:0]),
    .eoi_valid_o    (eoi_valid_o),
    .eoi_specific_o (eoi_specific_o),
    .eoi_line_o     (eoi_line_o)
  );

  pic_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .addr_i        (addr_i),
    .rd_pend_sel_i (rd_pend_sel_o),
    .pend_i        (pend_i),
    .insvc_i       (insvc_i),
    .mask_i        (mask_o),
    .rdata_o       (rdata_o)
  );
endmodule

// File: rtl/pic_cmd_seq_chk.sv
`timescale 1ns/1ps
module pic_cmd_seq_chk #(
  parameter int DATA_W = 8,
  localparam int LINE_W = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              is_master_i,
  input logic              wr_en_i,
  input logic              addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] pend_i,
  input logic [DATA_W-1:0] insvc_i,
  input logic [DATA_W-1:0] mask_o,
  input logic [DATA_W-1:0] vec_base_o,
  input logic              trig_edge_o,
  input logic              cascade_o,
  input logic [DATA_W-1:0] casc_map_o,
  input logic              auto_eoi_o,
  input logic              rd_pend_sel_o,
  input logic              eoi_valid_o,
  input logic              eoi_specific_o,
  input logic [LINE_W-1:0] eoi_line_o
);
  logic op2_wr;
  assign op2_wr = wr_en_i && !addr_i && (wdata_i[4:3] == 2'b00);

  p_init1_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wdata_i[4]) |=> (mask_o == '0) && (trig_edge_o == $past(wdata_i[3])));

  p_auto_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wdata_i[4] && !wdata_i[0]) |=> !auto_eoi_o);

  p_vec_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_base_o[LINE_W-1:0] == '0);

  p_slave_id_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_master_i |-> (casc_map_o[DATA_W-1:LINE_W] == '0));

  p_hold_cfg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_o) && $stable(vec_base_o) && $stable(casc_map_o)
                 && $stable(auto_eoi_o) && $stable(rd_pend_sel_o));

  p_eoi_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_valid_o |-> $past(op2_wr));

  p_eoi_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_valid_o && !eoi_specific_o) |-> (eoi_line_o == '0));

  p_eoi_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op2_wr && (wdata_i[7:5] != 3'b001) && (wdata_i[7:5] != 3'b011)) |=> !eoi_valid_o);
endmodule

bind pic_cmd_seq pic_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/pic_cmd_seq_bench.sv
`timescale 1ns/1ps
module pic_cmd_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       is_master = 1'b1;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] pend = 8'hA5;
  logic [7:0] insvc = 8'h3C;
  logic [7:0] rdata, mask, vec_base, casc_map;
  logic       trig_edge, cascade, auto_eoi, rd_sel, eoi_valid, eoi_spec;
  logic [2:0] eoi_line;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pic_cmd_seq u_pic_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .is_master_i(is_master),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pend_i(pend), .insvc_i(insvc), .mask_o(mask), .vec_base_o(vec_base),
    .trig_edge_o(trig_edge), .cascade_o(cascade), .casc_map_o(casc_map),
    .auto_eoi_o(auto_eoi), .rd_pend_sel_o(rd_sel), .eoi_valid_o(eoi_valid),
    .eoi_specific_o(eoi_spec), .eoi_line_o(eoi_line)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic master);
    @(negedge clk);
    rst_n = 1'b0;
    is_master = master;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive at a falling edge, captured at the next rising edge, returns at the falling edge after it
  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] r;
    do_reset(1'b1);
    chk("R1 mask", mask, 8'h00);
    chk("R1 auto_eoi", {7'd0, auto_eoi}, 8'h00);
    chk("R1 eoi_valid", {7'd0, eoi_valid}, 8'h00);
    rd(1'b0, r);
    chk("R1 read offset0 pending", r, 8'hA5);
  endtask

  task automatic t_mask_idle;
    logic [7:0] r;
    wr(1'b1, 8'h5A);
    chk("R7 mask load", mask, 8'h5A);
    rd(1'b1, r);
    chk("R11 read offset1", r, 8'h5A);
  endtask

  task automatic t_single_init;
    wr(1'b0, 8'h1A);  // edge, single, no word 4
    chk("R2 mask cleared", mask, 8'h00);
    chk("R2 edge flag", {7'd0, trig_edge}, 8'h01);
    chk("R2 single", {7'd0, cascade}, 8'h00);
    wr(1'b1, 8'h47);
    chk("R2 word2 not mask", mask, 8'h00);
    chk("R4 vector base", vec_base, 8'h40);
    chk("R4 map cleared", casc_map, 8'h00);
    wr(1'b1, 8'h33);
    chk("R4 back to idle", mask, 8'h33);
  endtask

  task automatic t_master_full;
    wr(1'b0, 8'h11);  // level, cascade, word 4
    chk("R2 level flag", {7'd0, trig_edge}, 8'h00);
    chk("R2 cascade", {7'd0, cascade}, 8'h01);
    wr(1'b1, 8'h27);
    chk("R4 vector base", vec_base, 8'h20);
    wr(1'b1, 8'hC4);
    chk("R5 master map", casc_map, 8'hC4);
    chk("R5 map not mask", mask, 8'h00);
    wr(1'b1, 8'h03);
    chk("R6 auto_eoi set", {7'd0, auto_eoi}, 8'h01);
    chk("R6 mask untouched", mask, 8'h00);
    wr(1'b1, 8'h81);
    chk("R6 idle after word4", mask, 8'h81);
  endtask

  task automatic t_auto_rules;
    wr(1'b0, 8'h13);  // single, word 4 requested
    chk("R3 auto_eoi kept", {7'd0, auto_eoi}, 8'h01);
    wr(1'b1, 8'h08);
    chk("R4 vector base", vec_base, 8'h08);
    wr(1'b1, 8'h02);
    chk("R4 single skips word4", mask, 8'h02);
    chk("R4 auto_eoi unchanged", {7'd0, auto_eoi}, 8'h01);
    wr(1'b0, 8'h10);  // cascade, no word 4
    chk("R3 auto_eoi cleared", {7'd0, auto_eoi}, 8'h00);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'hFF);
    chk("R5 master full byte", casc_map, 8'hFF);
    wr(1'b1, 8'h0F);
    chk("R5 idle without word4", mask, 8'h0F);
  endtask

  task automatic t_slave;
    do_reset(1'b0);
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h30);
    wr(1'b1, 8'hFE);
    chk("R5 slave id", casc_map, 8'h06);
    wr(1'b1, 8'h00);
    chk("R6 auto_eoi off", {7'd0, auto_eoi}, 8'h00);
    wr(1'b1, 8'h44);
    chk("R6 idle", mask, 8'h44);
  endtask

  task automatic t_eoi;
    wr(1'b0, 8'h27);  // code 001, low bits nonzero
    chk("R8 nonspec valid", {7'd0, eoi_valid}, 8'h01);
    chk("R8 nonspec flag", {7'd0, eoi_spec}, 8'h00);
    chk("R8 nonspec line", {5'd0, eoi_line}, 8'h00);
    @(negedge clk);
    chk("R8 one cycle", {7'd0, eoi_valid}, 8'h00);
    wr(1'b0, 8'h65);  // code 011, line 5
    chk("R8 spec valid", {7'd0, eoi_valid}, 8'h01);
    chk("R8 spec flag", {7'd0, eoi_spec}, 8'h01);
    chk("R8 spec line", {5'd0, eoi_line}, 8'h05);
    @(negedge clk);
    chk("R8 spec one cycle", {7'd0, eoi_valid}, 8'h00);
    chk("R8 mask kept", mask, 8'h44);
  endtask

  task automatic t_eoi_ignored;
    logic [7:0] m0, s0;
    m0 = mask;
    s0 = {7'd0, rd_sel};
    for (int c = 0; c < 8; c++) begin
      if (c == 1 || c == 3) continue;
      wr(1'b0, {c[2:0], 5'b00111});
      chk("R9 no pulse", {7'd0, eoi_valid}, 8'h00);
      chk("R9 mask kept", mask, m0);
      chk("R9 read select kept", {7'd0, rd_sel}, s0);
    end
  endtask

  task automatic t_read_sel;
    logic [7:0] r;
    wr(1'b0, 8'h0A);
    rd(1'b0, r);
    chk("R10 in-service selected", r, 8'h3C);
    wr(1'b0, 8'h09);
    rd(1'b0, r);
    chk("R10 bit1 clear no change", r, 8'h3C);
    wr(1'b0, 8'h0B);
    rd(1'b0, r);
    chk("R10 pending selected", r, 8'hA5);
    pend = 8'h96;
    rd(1'b0, r);
    chk("R11 follows pending input", r, 8'h96);
  endtask

  initial begin
    t_reset();
    t_mask_idle();
    t_single_init();
    t_master_full();
    t_auto_rules();
    t_slave();
    t_eoi();
    t_eoi_ignored();
    t_read_sel();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule